// File: doc/BRIEF.md
# Flash Readout Protection Gate

This block sits between the bus masters and the on-chip non-volatile storage (program flash, data EEPROM), the backup registers, the option-byte area and the boot ROM. A protection byte, sampled while reset is held and again on every option-byte reload request, chooses one of three protection levels. The block combines that level with the run context to decide whether each access is granted or answered with a bus error. The run context is the boot source latched at reset plus a debug-probe flag that latches once seen.

The level also drives two outputs. One enables the debug port. The other reports the boot source the rest of the chip must honour. At the strictest level the debug port is switched off for good, the boot source is pinned to flash, and option-byte writes are refused, so the level cannot be lowered again. Each access request carries a master tag, a region code and an access kind. One cycle later the block returns a response that echoes the tag with exactly one of grant or error.

Top module: `rdp_gate`

## Requirements
- R1: The protection byte decodes as 0xAA to the open level, 0xCC to the locked level, and any other value to the guarded level. It is sampled while `rst_n` is low and on any cycle with `opt_reload_i` high.
- R2: A request accepted on a clock edge with `req_valid_i` high produces `rsp_valid_o` high after that edge, with `rsp_master_o` equal to the request's tag and exactly one of `rsp_grant_o` / `rsp_err_o` high. With no request, all three response flags are low.
- R3: At the guarded level, the context is closed if debug is attached now, debug has been seen since the last reset or reload, or the latched boot source is RAM (1) or system loader (2). In a closed context, any kind of access to flash (region 0) or EEPROM (region 1) gets an error.
- R4: At the guarded level in a closed context, backup-register (region 2) reads (kind 0) and fetches (kind 2) get an error, while backup writes (kind 1) are granted. The option area (region 3) stays readable and writable. The boot ROM (region 4) stays readable and fetchable.
- R5: Writes to the boot ROM are always refused. Regions 5 to 7 and access kind 3 are always refused.
- R6: At the open level, and at the guarded level with an open context, flash, EEPROM and backup accesses of every kind are granted.
- R7: At the locked level `dbg_en_o` is low and `boot_sel_o` is 0 (flash) whatever `boot_req_i` is. An attached debug probe has no effect on access decisions.
- R8: At the locked level, option-area writes get an error. A reload keeps the locked level whatever byte is presented.
- R9: At the locked level, flash and EEPROM reads, writes and fetches, and backup reads and writes, are granted.
- R10: Once debug is seen at the guarded level, removing the probe does not reopen flash. A reload with the probe detached clears the record.
- R11: A reload that moves the level to locked clears both the debug record and a latched RAM or system-loader boot: `boot_sel_o` becomes 0 and flash access is granted.
- R12: Below the locked level, `boot_sel_o` holds the `boot_req_i` value sampled during reset, with code 3 mapped to 0 (flash). Later changes to `boot_req_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the protection byte and boot request are sampled while low |
| opt_byte_i | input | BYTE_W | Protection byte from the option area |
| opt_reload_i | input | 1 | Re-read the protection byte |
| boot_req_i | input | 2 | Boot pin request: 0 flash, 1 RAM, 2 system loader |
| dbg_attach_i | input | 1 | Debug probe attached |
| req_valid_i | input | 1 | Access request valid |
| req_master_i | input | MASTER_W | Requesting master tag |
| req_region_i | input | 3 | Target region code |
| req_kind_i | input | 2 | 0 read, 1 write/erase, 2 fetch |
| rsp_valid_o | output | 1 | Response valid |
| rsp_grant_o | output | 1 | Access granted |
| rsp_err_o | output | 1 | Bus error |
| rsp_master_o | output | MASTER_W | Echoed master tag |
| dbg_en_o | output | 1 | Debug port enable |
| boot_sel_o | output | 2 | Boot source to honour |

## Verification
The bench builds the block with a three-bit master tag, which is wider than the default, and keeps the default level codes. The wider tag exercises the response echo with tag values the default width cannot carry. The default codes let the bench reach all three levels from the bench's own byte choices, including an arbitrary byte that must land on the guarded level. Every region and kind combination is swept under each level and context. This covers reloads that lock the part while a RAM boot and a debug record are latched, and a reload that tries to unlock a locked part.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN  = 2'd0,
        LVL_GUARD = 2'd1,
        LVL_LOCK  = 2'd2
    } rdp_level_e;

    localparam int REGION_W = 3;
    localparam int KIND_W   = 2;
    localparam int BOOT_W   = 2;

    localparam logic [BOOT_W-1:0] BOOT_FLASH  = 2'd0;
    localparam logic [BOOT_W-1:0] BOOT_RAM    = 2'd1;
    localparam logic [BOOT_W-1:0] BOOT_SYSLDR = 2'd2;

    localparam logic [REGION_W-1:0] RGN_FLASH  = 3'd0;
    localparam logic [REGION_W-1:0] RGN_EEPROM = 3'd1;
    localparam logic [REGION_W-1:0] RGN_BACKUP = 3'd2;
    localparam logic [REGION_W-1:0] RGN_OPTION = 3'd3;
    localparam logic [REGION_W-1:0] RGN_SYSMEM = 3'd4;

    localparam logic [KIND_W-1:0] KIND_READ  = 2'd0;
    localparam logic [KIND_W-1:0] KIND_WRITE = 2'd1;
    localparam logic [KIND_W-1:0] KIND_FETCH = 2'd2;
    localparam logic [KIND_W-1:0] KIND_BAD   = 2'd3;

    typedef struct packed {
        rdp_level_e        level;
        logic [BOOT_W-1:0] boot;
        logic              dbg_seen;
    } rdp_ctx_t;

endpackage

// File: rtl/rdp_level_decode.sv
module rdp_level_decode
    import rdp_pkg::*;
#(
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA,
    parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hCC
) (
    input  logic [BYTE_W-1:0] byte_i,
    output rdp_level_e        level_o
);

    // Any byte other than the two exact codes lands on the guarded level.
    always_comb begin
        if (byte_i == LOCK_CODE) begin
            level_o = LVL_LOCK;
        end else if (byte_i == OPEN_CODE) begin
            level_o = LVL_OPEN;
        end else begin
            level_o = LVL_GUARD;
        end
    end

endmodule

// File: rtl/rdp_ctx_track.sv
module rdp_ctx_track
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rdp_level_e        load_level_i,
    input  logic              opt_reload_i,
    input  logic [BOOT_W-1:0] boot_req_i,
    input  logic              dbg_attach_i,
    output rdp_ctx_t          ctx_o
);

    rdp_ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (!rst_n) begin
            ctx_d.level    = load_level_i;
            ctx_d.dbg_seen = 1'b0;
            if (load_level_i == LVL_LOCK || boot_req_i == 2'd3) begin
                ctx_d.boot = BOOT_FLASH;
            end else begin
                ctx_d.boot = boot_req_i;
            end
        end else if (opt_reload_i) begin
            // A locked part stays locked; the option bytes cannot change.
            ctx_d.level    = (ctx_q.level == LVL_LOCK) ? LVL_LOCK : load_level_i;
            ctx_d.dbg_seen = 1'b0;
            if (ctx_d.level == LVL_LOCK) begin
                ctx_d.boot = BOOT_FLASH;
            end
        end else if (ctx_q.level != LVL_LOCK && dbg_attach_i) begin
            ctx_d.dbg_seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        ctx_q <= ctx_d;
    end

    assign ctx_o = ctx_q;

endmodule

// File: rtl/rdp_access_policy.sv
module rdp_access_policy
    import rdp_pkg::*;
(
    input  rdp_ctx_t            ctx_i,
    input  logic                dbg_live_i,
    input  logic [REGION_W-1:0] region_i,
    input  logic [KIND_W-1:0]   kind_i,
    output logic                grant_o
);

    logic closed;
    logic is_write;
    logic region_ok;

    always_comb begin
        closed   = (ctx_i.level == LVL_GUARD) &&
                   (ctx_i.dbg_seen || dbg_live_i || ctx_i.boot != BOOT_FLASH);
        is_write = (kind_i == KIND_WRITE);
        case (region_i)
            RGN_FLASH,
            RGN_EEPROM: region_ok = !closed;
            RGN_BACKUP: region_ok = is_write || !closed;
            RGN_OPTION: region_ok = !(ctx_i.level == LVL_LOCK && is_write);
            RGN_SYSMEM: region_ok = !is_write;
            default:    region_ok = 1'b0;
        endcase
        grant_o = region_ok && (kind_i != KIND_BAD);
    end

endmodule

// File: rtl/rdp_gate.sv
module rdp_gate
    import rdp_pkg::*;
#(
    parameter int                MASTER_W  = 2,
    parameter int                BYTE_W    = 8,
    parameter logic [BYTE_W-1:0] OPEN_CODE = 8'hAA,
    parameter logic [BYTE_W-1:0] LOCK_CODE = 8'hCC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   opt_byte_i,
    input  logic                opt_reload_i,
    input  logic [1:0]          boot_req_i,
    input  logic                dbg_attach_i,
    input  logic                req_valid_i,
    input  logic [MASTER_W-1:0] req_master_i,
    input  logic [2:0]          req_region_i,
    input  logic [1:0]          req_kind_i,
    output logic                rsp_valid_o,
    output logic                rsp_grant_o,
    output logic                rsp_err_o,
    output logic [MASTER_W-1:0] rsp_master_o,
    output logic                dbg_en_o,
    output logic [1:0]          boot_sel_o
);

    typedef struct packed {
        logic                valid;
        logic                grant;
        logic [MASTER_W-1:0] master;
    } rsp_t;

    rdp_level_e load_level;
    rdp_ctx_t   ctx;
    logic       pol_grant;
    logic       dbg_live;
    rsp_t       rsp_d, rsp_q;

    rdp_level_decode #(
        .BYTE_W    (BYTE_W),
        .OPEN_CODE (OPEN_CODE),
        .LOCK_CODE (LOCK_CODE)
    ) u_decode (
        .byte_i  (opt_byte_i),
        .level_o (load_level)
    );

    rdp_ctx_track u_ctx (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_level_i (load_level),
        .opt_reload_i (opt_reload_i),
        .boot_req_i   (boot_req_i),
        .dbg_attach_i (dbg_attach_i),
        .ctx_o        (ctx)
    );

    // A locked part has no debug port, so a probe there changes nothing.
    assign dbg_live = dbg_attach_i && (ctx.level != LVL_LOCK);

    rdp_access_policy u_policy (
        .ctx_i      (ctx),
        .dbg_live_i (dbg_live),
        .region_i   (req_region_i),
        .kind_i     (req_kind_i),
        .grant_o    (pol_grant)
    );

    always_comb begin
        rsp_d = '0;
        if (rst_n && req_valid_i) begin
            rsp_d.valid  = 1'b1;
            rsp_d.grant  = pol_grant;
            rsp_d.master = req_master_i;
        end
    end

    always_ff @(posedge clk) begin
        rsp_q <= rsp_d;
    end

    assign rsp_valid_o  = rsp_q.valid;
    assign rsp_grant_o  = rsp_q.valid && rsp_q.grant;
    assign rsp_err_o    = rsp_q.valid && !rsp_q.grant;
    assign rsp_master_o = rsp_q.master;
    assign dbg_en_o     = (ctx.level != LVL_LOCK);
    assign boot_sel_o   = ctx.boot;

endmodule

// File: rtl/rdp_gate_chk.sv
module rdp_gate_chk
    import rdp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid_i,
    input logic [2:0] req_region_i,
    input logic [1:0] req_kind_i,
    input logic       dbg_attach_i,
    input logic       rsp_valid_o,
    input logic       rsp_grant_o,
    input logic       rsp_err_o,
    input logic       dbg_en_o,
    input logic [1:0] boot_sel_o,
    input rdp_level_e level_i
);

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);

    p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_grant_o != rsp_err_o));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> !(rsp_grant_o || rsp_err_o));

    p_guard_dbg_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && level_i == LVL_GUARD && dbg_attach_i &&
         (req_region_i == RGN_FLASH || req_region_i == RGN_EEPROM)) |=> rsp_err_o);

    p_sysmem_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_region_i == RGN_SYSMEM && req_kind_i == KIND_WRITE) |=> rsp_err_o);

    p_lock_boot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en_o |-> (boot_sel_o == BOOT_FLASH));

    p_lock_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_en_o |=> !dbg_en_o);

    p_lock_optwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en_o && req_valid_i && req_region_i == RGN_OPTION &&
         req_kind_i == KIND_WRITE) |=> rsp_err_o);

endmodule

bind rdp_gate rdp_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_region_i (req_region_i),
    .req_kind_i   (req_kind_i),
    .dbg_attach_i (dbg_attach_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_grant_o  (rsp_grant_o),
    .rsp_err_o    (rsp_err_o),
    .dbg_en_o     (dbg_en_o),
    .boot_sel_o   (boot_sel_o),
    .level_i      (ctx.level)
);

// File: tb/rdp_gate_tb.sv
module rdp_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MW         = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    opt_byte = 8'hAA;
    logic          opt_reload = 1'b0;
    logic [1:0]    boot_req = 2'd0;
    logic          dbg_attach = 1'b0;
    logic          req_valid = 1'b0;
    logic [MW-1:0] req_master = '0;
    logic [2:0]    req_region = '0;
    logic [1:0]    req_kind = '0;
    logic          rsp_valid, rsp_grant, rsp_err, dbg_en;
    logic [MW-1:0] rsp_master;
    logic [1:0]    boot_sel;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    live = 1'b0;
    bit    done = 1'b0;

    // reference model state
    int m_lvl, m_boot;
    bit m_dbg, e_valid, e_grant;
    int e_master;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdp_gate #(.MASTER_W(MW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .opt_byte_i   (opt_byte),
        .opt_reload_i (opt_reload),
        .boot_req_i   (boot_req),
        .dbg_attach_i (dbg_attach),
        .req_valid_i  (req_valid),
        .req_master_i (req_master),
        .req_region_i (req_region),
        .req_kind_i   (req_kind),
        .rsp_valid_o  (rsp_valid),
        .rsp_grant_o  (rsp_grant),
        .rsp_err_o    (rsp_err),
        .rsp_master_o (rsp_master),
        .dbg_en_o     (dbg_en),
        .boot_sel_o   (boot_sel)
    );

    function automatic int lvl_of(logic [7:0] b);
        if (b == 8'hCC) return 2;
        if (b == 8'hAA) return 0;
        return 1;
    endfunction

    function automatic bit allow(int lvl, int boot, bit seen, bit probe, int rgn, int knd);
        bit shut;
        shut = (lvl == 1) && (seen || probe || boot != 0);
        if (knd == 3) return 1'b0;
        case (rgn)
            0, 1: return !shut;
            2:    return (knd == 1) || !shut;
            3:    return !(lvl == 2 && knd == 1);
            4:    return knd != 1;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        live = 1'b1;
        if (!rst_n) begin
            m_lvl   = lvl_of(opt_byte);
            m_boot  = (m_lvl == 2 || boot_req == 2'd3) ? 0 : int'(boot_req);
            m_dbg   = 1'b0;
            e_valid = 1'b0;
            e_grant = 1'b0;
            e_master = 0;
        end else begin
            e_valid = req_valid;
            e_grant = req_valid && allow(m_lvl, m_boot, m_dbg,
                                         dbg_attach && m_lvl != 2,
                                         int'(req_region), int'(req_kind));
            e_master = req_valid ? int'(req_master) : 0;
            if (opt_reload) begin
                if (m_lvl != 2) m_lvl = lvl_of(opt_byte);
                m_dbg = 1'b0;
                if (m_lvl == 2) m_boot = 0;
            end else if (m_lvl != 2 && dbg_attach) begin
                m_dbg = 1'b1;
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            check("rsp_valid", rsp_valid, e_valid);
            check("rsp_grant", rsp_grant, e_grant);
            check("rsp_err", rsp_err, e_valid && !e_grant);
            if (e_valid) check("rsp_master", rsp_master, e_master);
            check("dbg_en", dbg_en, m_lvl != 2);
            check("boot_sel", boot_sel, m_boot);
        end
    end

    task automatic do_reset(logic [7:0] b, logic [1:0] boot, logic probe);
        @(negedge clk);
        rst_n = 1'b0; opt_byte = b; boot_req = boot; dbg_attach = probe;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reload(logic [7:0] b);
        @(negedge clk);
        opt_byte = b; opt_reload = 1'b1;
        @(negedge clk);
        opt_reload = 1'b0;
    endtask

    // every region and kind, back to back, rotating master tags
    task automatic sweep();
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                req_valid  = 1'b1;
                req_region = 3'(r);
                req_kind   = 2'(k);
                req_master = MW'(r + k);
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic one(int r, int k);
        @(negedge clk);
        req_valid = 1'b1; req_region = 3'(r); req_kind = 2'(k);
        req_master = MW'(7);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // R1 / R6 / R12: open level, RAM boot latched, probe attached
        tag = "R1"; do_reset(8'hAA, 2'd1, 1'b1);
        tag = "R6"; sweep();
        tag = "R12"; boot_req = 2'd2; repeat (3) @(negedge clk);
        // R2: gaps between requests
        tag = "R2"; one(0, 0); one(4, 2);

        // guarded, flash boot, open context
        tag = "R1"; do_reset(8'h55, 2'd0, 1'b0);
        tag = "R6"; sweep();
        tag = "R3"; dbg_attach = 1'b1; sweep();
        tag = "R4"; sweep();
        tag = "R10"; dbg_attach = 1'b0; sweep();
        reload(8'h13); sweep();
        tag = "R5"; one(4, 1); one(6, 0); one(0, 3);

        // guarded, system-loader boot
        tag = "R3"; do_reset(8'h00, 2'd2, 1'b0); sweep();
        tag = "R12"; boot_req = 2'd0; one(0, 0);
        do_reset(8'hFF, 2'd3, 1'b0); one(0, 0);

        // locked level
        tag = "R7"; do_reset(8'hCC, 2'd1, 1'b1); sweep();
        tag = "R9"; dbg_attach = 1'b0; sweep();
        tag = "R8"; one(3, 1); reload(8'hAA); one(3, 1); one(3, 0);

        // guarded with RAM boot and probe record, then lock by reload
        tag = "R11"; do_reset(8'h5A, 2'd1, 1'b0);
        dbg_attach = 1'b1; one(0, 0); dbg_attach = 1'b0;
        reload(8'hCC); sweep();

        done = 1'b1;
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule